// File: doc/BRIEF.md
# Pixel Trigger Combiner

This block merges the per-channel hit information of a sixteen-channel photon counting front end into the signals the next trigger level uses. Each channel supplies a raw discriminator pulse and a digital comparator flag that says its photon count has crossed its threshold. Each channel also has two enable bits of its own: one for the coordinate trigger and one for the fast OR.

The channels are placed on a square pixel grid. The block drives one column line and one row line for every channel whose coordinate enable is set and whose comparator is active. A single fast OR line is high while any channel with its OR enable set has its discriminator pulse high together with its comparator flag. A monitor pin shows the raw discriminator pulse of one selected channel, for testing the front end.

All outputs are combinational. They follow the inputs without a clock, so a trigger decision is not delayed until the next frame boundary.

Top module: `trig_combiner`

## Requirements
- R1: Channel i sits at column i mod 4 and row i div 4 of a 4×4 grid, for i from 0 to 15.
- R2: Column line c is high exactly when some channel in column c has its coordinate enable set and its comparator flag high.
- R3: Row line r is high exactly when some channel in row r has its coordinate enable set and its comparator flag high.
- R4: The discriminator pulses have no effect on the column and row lines.
- R5: The fast OR is high exactly when some channel has its OR enable, its discriminator pulse and its comparator flag all high.
- R6: The coordinate enables have no effect on the fast OR, and the OR enables have no effect on the column and row lines.
- R7: When monitor selector bit 4 is 1, the monitor output equals the raw discriminator pulse of the channel numbered by selector bits 3:0, whatever that channel's enables and comparator flag are.
- R8: When monitor selector bit 4 is 0, the monitor output is 0.
- R9: With every enable bit and selector bit 4 at 0, all outputs are 0, and every output settles to its new value without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| disc_i | input | 16 | Raw discriminator pulse per channel |
| cmp_i | input | 16 | Digital comparator flag per channel |
| xy_en_i | input | 16 | Coordinate trigger enable per channel |
| or_en_i | input | 16 | Fast OR enable per channel |
| mon_sel_i | input | 5 | Monitor selector: bit 4 enable, bits 3:0 channel |
| x_o | output | 4 | Column trigger lines |
| y_o | output | 4 | Row trigger lines |
| fast_or_o | output | 1 | Fast OR of gated discriminator pulses |
| mon_o | output | 1 | Monitored raw discriminator pulse |

## Verification
Every result of this block is due in the same time step as the input change that causes it, since no register lies between any input and any output. The bench therefore applies each input pattern, waits a fixed settling delay with no clock involved, and only then compares all four outputs with values it computes from the grid mapping. Sweeps walk each channel alone, run a long pseudo-random series of flag and enable patterns, and step the monitor selector through all 32 values.

// File: rtl/trig_combiner.sv
module trig_combiner #(
  parameter int COLS = 4,
  parameter int ROWS = 4,
  localparam int NCH = COLS * ROWS,
  localparam int IDXW = $clog2(NCH),
  localparam int SELW = IDXW + 1
) (
  input  logic [NCH-1:0]  disc_i,
  input  logic [NCH-1:0]  cmp_i,
  input  logic [NCH-1:0]  xy_en_i,
  input  logic [NCH-1:0]  or_en_i,
  input  logic [SELW-1:0] mon_sel_i,
  output logic [COLS-1:0] x_o,
  output logic [ROWS-1:0] y_o,
  output logic            fast_or_o,
  output logic            mon_o
);

  always_comb begin
    logic [NCH-1:0] xy_hit;
    xy_hit = xy_en_i & cmp_i;
    x_o = '0;
    y_o = '0;
    for (int i = 0; i < NCH; i++) begin
      x_o[i % COLS] = x_o[i % COLS] | xy_hit[i];
      y_o[i / COLS] = y_o[i / COLS] | xy_hit[i];
    end
    fast_or_o = |(or_en_i & disc_i & cmp_i);
    mon_o = mon_sel_i[SELW-1] & disc_i[mon_sel_i[IDXW-1:0]];

    AST_XY_PAIRED: assert ((x_o != '0) == (y_o != '0));                    // R3
    AST_XY_NEEDS_FLAG: assert ((x_o == '0) || ((xy_en_i & cmp_i) != '0));  // R2
    AST_FOR_NEEDS_PULSE: assert (!fast_or_o || ((disc_i & cmp_i) != '0));  // R5
    AST_MON_OFF: assert (mon_sel_i[SELW-1] || !mon_o);                     // R8
    AST_MON_RAW: assert (!mon_o || (disc_i != '0));                         // R7
    AST_IDLE: assert (!((xy_en_i == '0) && (or_en_i == '0) && !mon_sel_i[SELW-1])
                      || ((x_o == '0) && (y_o == '0) && !fast_or_o && !mon_o)); // R9
  end

endmodule

// File: tb/sim_trig_combiner.sv
module sim_trig_combiner;
  localparam int STEP = 10;
  localparam int NCH = 16;

  logic [15:0] disc, cmp, xy_en, or_en;
  logic [4:0]  sel;
  logic [3:0]  x, y;
  logic        fo, mon;
  int checks = 0;
  int fails = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  trig_combiner u0 (.disc_i(disc), .cmp_i(cmp), .xy_en_i(xy_en), .or_en_i(or_en),
                    .mon_sel_i(sel), .x_o(x), .y_o(y), .fast_or_o(fo), .mon_o(mon));

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [3:0] ex, ey;
    logic ef, em;
    ex = '0; ey = '0; ef = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (xy_en[i] && cmp[i]) begin
        ex[i % 4] = 1'b1;
        ey[i / 4] = 1'b1;
      end
      if (or_en[i] && disc[i] && cmp[i]) ef = 1'b1;
    end
    em = sel[4] ? disc[sel[3:0]] : 1'b0;
    #(STEP);
    chk({tag, " R1 R2 x"}, x, ex);
    chk({tag, " R1 R3 y"}, y, ey);
    chk({tag, " R5 fast_or"}, {3'b0, fo}, {3'b0, ef});
    chk({tag, sel[4] ? " R7 mon" : " R8 mon"}, {3'b0, mon}, {3'b0, em});
  endtask

  initial begin
    #(STEP * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] xs, ys;
    // R9: idle state, no clock anywhere
    disc = '1; cmp = '1; xy_en = '0; or_en = '0; sel = 5'h0F;
    check_all("R9 idle");
    chk("R9 idle all-zero", {x | y, fo, mon} == 0 ? 4'h0 : 4'hF, 4'h0);

    // R1: walk single channel through the grid
    for (int i = 0; i < NCH; i++) begin
      disc = 16'h1 << i; cmp = 16'h1 << i; xy_en = '1; or_en = '1; sel = 5'(16 + i);
      check_all("R1 walk");
      chk("R1 column", x, 4'h1 << (i % 4));
      chk("R1 row", y, 4'h1 << (i / 4));
    end

    // R4: discriminator pulses do not change X/Y
    cmp = 16'h8421; xy_en = '1; or_en = '0; sel = 5'h00;
    disc = '0; #(STEP); xs = x; ys = y;
    disc = '1; check_all("R4");
    chk("R4 x unchanged", x, xs);
    chk("R4 y unchanged", y, ys);

    // R6: each enable set leaves the other output untouched
    disc = '1; cmp = 16'h0100; or_en = 16'h0100; xy_en = '0;
    check_all("R6 or only");
    chk("R6 x stays low", x, 4'h0);
    chk("R6 fast_or high", {3'b0, fo}, 4'h1);
    or_en = '0; xy_en = 16'h0100;
    check_all("R6 xy only");
    chk("R6 fast_or stays low", {3'b0, fo}, 4'h0);

    // R7/R8: full monitor selector sweep, enables cleared
    xy_en = '0; or_en = '0; cmp = '0;
    for (int s = 0; s < 32; s++) begin
      sel = 5'(s);
      disc = 16'h1 << (s % 16);
      check_all("R7 R8 sel");
      disc = ~(16'h1 << (s % 16));
      check_all("R7 R8 sel inv");
    end

    // R2 R3 R5: pseudo-random patterns
    for (int n = 0; n < 400; n++) begin
      lfsr = nxt(lfsr); disc = lfsr[15:0]; cmp = lfsr[31:16];
      lfsr = nxt(lfsr); xy_en = lfsr[15:0] & lfsr[31:16];
      lfsr = nxt(lfsr); or_en = lfsr[15:0] | lfsr[31:16];
      sel = lfsr[4:0];
      check_all("R2 R3 R5 rand");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule